// File: doc/BRIEF.md
# Approximate Unsigned Restoring Array Divider

This block is a purely combinational unsigned divider. It takes a dividend of twice the operand width and a divisor of the operand width. It returns a quotient and a remainder, both of the operand width. The datapath is a square array of one-bit subtractor cells with one row per quotient bit. The top row produces the most significant quotient bit. Each row subtracts the divisor from the partial remainder of the row above, after that remainder has been shifted left by one place and the next dividend bit appended. The borrow ripples from the right-hand cell to the left-hand cell of the row. The final borrow, together with the bit shifted out of the top of the remainder, gives the row's quotient bit. That quotient bit then tells every cell in the row whether to keep its new difference or to restore its old minuend.

Three compile-time parameters trade accuracy for a shorter critical path:
- **Cell variant.** The array can use exact cells or one of two approximate cells. One approximate cell cuts the borrow ripple along a row. The other drops the restore multiplexer and so cuts the dependence between rows.
- **Placement order.** Approximate cells are placed in row order, column order or diagonal order.
- **Depth.** This is how many cells take the approximate variant.

With a depth of zero the block is an exact divider. Typical users are pixel-ratio operations that tolerate small errors.

Top module: `apx_array_divider`

## Requirements
- R1: With depth 0 (or the exact cell variant), for every dividend A and nonzero divisor B whose upper half of A is below B, the outputs satisfy Q*B + R = A and R < B.
- R2: With N_BITS = 4 and depth 0, dividend 0x2E over divisor 0xB gives quotient 0x4 and remainder 0x2.
- R3: In a row built only from exact cells whose incoming partial remainder is below the divisor: the quotient bit is 1 exactly when the appended value is at least the divisor; a 1 keeps the difference; a 0 restores the appended low bits. Quotient bit k comes from the row counted k from the bottom.
- R4: The loose-borrow cell has an exact difference and restore path. Its borrow out is (not minuend) and subtrahend, with borrow in ignored. This differs from the exact borrow in exactly 4 of the 16 rows of (minuend, subtrahend, borrow in, keep).
- R5: The loose-difference cell has an exact borrow out. Its result is minuend xor subtrahend xor borrow in whatever the keep input is. This differs from the exact result in exactly 4 of the 16 rows (keep = 0 with subtrahend different from borrow in).
- R6: Cell position (row r counted from the bottom, column c counted from the right, where column 0 takes the appended dividend bit). Row order gives that cell rank r*N_BITS + c.
- R7: Column order gives the cell at (r, c) rank c*N_BITS + r.
- R8: Diagonal order ranks cells by r + c ascending, and by r ascending within equal r + c.
- R9: The cells with rank below DEPTH take the selected variant and all others stay exact; a DEPTH of N_BITS*N_BITS or more makes every cell approximate.
- R10: A row made entirely of loose-difference cells outputs (appended value minus divisor) modulo 2^N_BITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | 2*N_BITS | Unsigned dividend |
| divisor | input | N_BITS | Unsigned divisor |
| quotient | output | N_BITS | Quotient, MSB from the top row |
| remainder | output | N_BITS | Partial remainder leaving the bottom row |

## Verification
The arithmetic checks only hold for legal operands:
- the divisor must be nonzero;
- the upper half of the dividend must be strictly below the divisor, so the quotient fits.

The row checks also require the incoming partial remainder to be below the divisor. This holds automatically below exact rows, so each row guards its own checks with that comparison. The stimulus sweeps every legal operand pair of the 8-by-4 configuration and never applies an illegal one. A single-cell sweep covers all 16 input rows of each cell variant.

// File: rtl/apx_div_pkg.sv
package apx_div_pkg;

    typedef enum logic [1:0] {
        CELL_EXACT        = 2'd0,
        CELL_LOOSE_BORROW = 2'd1,
        CELL_LOOSE_DIFF   = 2'd2
    } cell_kind_e;

    typedef enum logic [1:0] {
        SWEEP_ROWS = 2'd0,
        SWEEP_COLS = 2'd1,
        SWEEP_DIAG = 2'd2
    } sweep_e;

    typedef struct packed {
        logic minu;
        logic subt;
        logic bin;
        logic keep;
    } cell_in_t;

    typedef struct packed {
        logic res;
        logic bout;
    } cell_out_t;

    // exact full-subtractor borrow
    function automatic logic exact_borrow(input cell_in_t ci);
        return (~ci.minu & ci.subt) | (~(ci.minu ^ ci.subt) & ci.bin);
    endfunction

    function automatic logic raw_diff(input cell_in_t ci);
        return ci.minu ^ ci.subt ^ ci.bin;
    endfunction

    // rank of cell (row from bottom, column from right) in the chosen order
    function automatic int cell_rank(input sweep_e sw, input int n,
                                     input int row, input int col);
        int cnt;
        cnt = 0;
        case (sw)
            SWEEP_ROWS: cnt = row * n + col;
            SWEEP_COLS: cnt = col * n + row;
            default: begin
                for (int rr = 0; rr < n; rr++) begin
                    for (int cc = 0; cc < n; cc++) begin
                        if ((rr + cc < row + col) ||
                            ((rr + cc == row + col) && (rr < row)))
                            cnt++;
                    end
                end
            end
        endcase
        return cnt;
    endfunction

    function automatic bit cell_swapped(input sweep_e sw, input int n,
                                        input int depth, input int row,
                                        input int col);
        return cell_rank(sw, n, row, col) < depth;
    endfunction

    function automatic int row_swap_count(input sweep_e sw, input int n,
                                          input int depth, input int row);
        int cnt;
        cnt = 0;
        for (int cc = 0; cc < n; cc++)
            if (cell_swapped(sw, n, depth, row, cc)) cnt++;
        return cnt;
    endfunction

endpackage

// File: rtl/apx_sub_cell.sv
// One-bit restoring subtractor cell.
// Inputs (minu, subt, bin, keep); keep is the row quotient bit.
//   exact       : bout = ~m&s | ~(m^s)&bin ; res = keep ? m^s^bin : m
//   loose borrow: bout = ~m&s               ; res as exact
//   loose diff  : bout as exact             ; res = m^s^bin
// Rows where the loose variants differ from exact (m s bin keep):
//   loose borrow bout: 0010 0011 1110 1111
//   loose diff   res : 0100 0010 1100 1010
module apx_sub_cell #(
    parameter apx_div_pkg::cell_kind_e KIND = apx_div_pkg::CELL_EXACT
) (
    input  logic minu,
    input  logic subt,
    input  logic bin,
    input  logic keep,
    output logic res,
    output logic bout
);
    import apx_div_pkg::*;

    cell_in_t  ci;
    cell_out_t co;
    logic      ref_bout;
    logic      ref_res;

    always_comb begin
        ci       = '{minu: minu, subt: subt, bin: bin, keep: keep};
        ref_bout = exact_borrow(ci);
        ref_res  = keep ? raw_diff(ci) : minu;
    end

    generate
        if (KIND == CELL_LOOSE_BORROW) begin : g_loose_borrow
            always_comb begin
                co.bout = ~ci.minu & ci.subt;
                co.res  = ci.keep ? raw_diff(ci) : ci.minu;
            end
        end else if (KIND == CELL_LOOSE_DIFF) begin : g_loose_diff
            always_comb begin
                co.bout = exact_borrow(ci);
                co.res  = raw_diff(ci);
            end
        end else begin : g_exact
            always_comb begin
                co.bout = exact_borrow(ci);
                co.res  = ci.keep ? raw_diff(ci) : ci.minu;
            end
        end
    endgenerate

    assign res  = co.res;
    assign bout = co.bout;

    always_comb begin
        if (KIND == CELL_LOOSE_BORROW) begin
            // R4: the cut borrow only ever drops a borrow, never adds one
            assert_borrow_under_R4: assert (!(bout && !ref_bout));
            assert_res_kept_R4: assert (res == ref_res);
        end
        if (KIND == CELL_LOOSE_DIFF) begin
            // R5: with keep set the unrestored result is the exact one
            assert_keep_match_R5: assert (!keep || (res == ref_res));
            assert_borrow_kept_R5: assert (bout == ref_bout);
        end
    end

endmodule

// File: rtl/apx_div_row.sv
module apx_div_row #(
    parameter int                      N_BITS    = 4,
    parameter apx_div_pkg::cell_kind_e CELL_KIND = apx_div_pkg::CELL_EXACT,
    parameter apx_div_pkg::sweep_e     SWEEP     = apx_div_pkg::SWEEP_ROWS,
    parameter int                      DEPTH     = 0,
    parameter int                      ROW_IDX   = 0
) (
    input  logic [N_BITS-1:0] part_in,
    input  logic              next_bit,
    input  logic [N_BITS-1:0] divisor,
    output logic              q_bit,
    output logic [N_BITS-1:0] part_out
);
    import apx_div_pkg::*;

    localparam int SWAPS    = row_swap_count(SWEEP, N_BITS, DEPTH, ROW_IDX);
    localparam bit ALL_EXACT = (SWAPS == 0) || (CELL_KIND == CELL_EXACT);
    localparam bit ALL_DIFF  = (CELL_KIND == CELL_LOOSE_DIFF) && (SWAPS == N_BITS);

    logic [N_BITS:0]   widened;
    logic              borrow [N_BITS+1];
    logic [N_BITS-1:0] res_bits;

    assign widened   = {part_in, next_bit};
    assign borrow[0] = 1'b0;

    generate
        for (genvar j = 0; j < N_BITS; j++) begin : g_col
            localparam bit         SWAP = cell_swapped(SWEEP, N_BITS, DEPTH, ROW_IDX, j);
            localparam cell_kind_e KSEL = SWAP ? CELL_KIND : CELL_EXACT;
            apx_sub_cell #(.KIND(KSEL)) u_cell (
                .minu (widened[j]),
                .subt (divisor[j]),
                .bin  (borrow[j]),
                .keep (q_bit),
                .res  (res_bits[j]),
                .bout (borrow[j+1])
            );
        end
    endgenerate

    // the bit shifted out above the cells guarantees a non-negative result
    assign q_bit    = widened[N_BITS] | ~borrow[N_BITS];
    assign part_out = res_bits;

    always_comb begin
        if (ALL_EXACT && (part_in < divisor)) begin
            assert_row_select_R3: assert (q_bit == (widened >= {1'b0, divisor}));
            assert_row_bound_R3: assert (part_out < divisor);
        end
        if (ALL_DIFF) begin
            assert_raw_wrap_R10: assert ({1'b0, part_out} ==
                ((widened - {1'b0, divisor}) & {1'b0, {N_BITS{1'b1}}}));
        end
    end

endmodule

// File: rtl/apx_array_divider.sv
module apx_array_divider #(
    parameter int                      N_BITS    = 4,
    parameter apx_div_pkg::cell_kind_e CELL_KIND = apx_div_pkg::CELL_EXACT,
    parameter apx_div_pkg::sweep_e     SWEEP     = apx_div_pkg::SWEEP_ROWS,
    parameter int                      DEPTH     = 0
) (
    input  logic [2*N_BITS-1:0] dividend,
    input  logic [N_BITS-1:0]   divisor,
    output logic [N_BITS-1:0]   quotient,
    output logic [N_BITS-1:0]   remainder
);
    import apx_div_pkg::*;

    localparam int WIDE     = 2 * N_BITS;
    localparam bit IS_EXACT = (DEPTH == 0) || (CELL_KIND == CELL_EXACT);

    logic [N_BITS-1:0] part [N_BITS+1];

    assign part[0] = dividend[WIDE-1:N_BITS];

    generate
        for (genvar k = 0; k < N_BITS; k++) begin : g_row
            apx_div_row #(
                .N_BITS    (N_BITS),
                .CELL_KIND (CELL_KIND),
                .SWEEP     (SWEEP),
                .DEPTH     (DEPTH),
                .ROW_IDX   (N_BITS - 1 - k)
            ) u_row (
                .part_in  (part[k]),
                .next_bit (dividend[N_BITS-1-k]),
                .divisor  (divisor),
                .q_bit    (quotient[N_BITS-1-k]),
                .part_out (part[k+1])
            );
        end
    endgenerate

    assign remainder = part[N_BITS];

    logic [WIDE-1:0] rebuilt;
    always_comb begin
        rebuilt = ({{N_BITS{1'b0}}, quotient} * {{N_BITS{1'b0}}, divisor})
                + {{N_BITS{1'b0}}, remainder};
        if (IS_EXACT && (divisor != '0) &&
            (dividend[WIDE-1:N_BITS] < divisor)) begin
            assert_identity_R1: assert (rebuilt == dividend);
            assert_rem_bound_R1: assert (remainder < divisor);
        end
    end

endmodule

// File: tb/test_apx_array_divider.sv
`timescale 1ns/1ps
module test_apx_array_divider;
    import apx_div_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0] dvd = 8'd0;
    logic [3:0] dvs = 4'd1;
    logic [3:0] q0, r0, q1, r1, q2, r2, q3, r3, q4, r4, q5, r5;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int rank_tab [3][16];

    // c0: loose borrow, depth 0 -> exact
    apx_array_divider #(.N_BITS(4), .CELL_KIND(CELL_LOOSE_BORROW), .SWEEP(SWEEP_ROWS), .DEPTH(0))
        i_apx_array_divider (.dividend(dvd), .divisor(dvs), .quotient(q0), .remainder(r0));
    apx_array_divider #(.N_BITS(4), .CELL_KIND(CELL_LOOSE_BORROW), .SWEEP(SWEEP_ROWS), .DEPTH(6))
        i_apx_array_divider_c1 (.dividend(dvd), .divisor(dvs), .quotient(q1), .remainder(r1));
    apx_array_divider #(.N_BITS(4), .CELL_KIND(CELL_LOOSE_DIFF), .SWEEP(SWEEP_COLS), .DEPTH(7))
        i_apx_array_divider_c2 (.dividend(dvd), .divisor(dvs), .quotient(q2), .remainder(r2));
    apx_array_divider #(.N_BITS(4), .CELL_KIND(CELL_LOOSE_BORROW), .SWEEP(SWEEP_DIAG), .DEPTH(9))
        i_apx_array_divider_c3 (.dividend(dvd), .divisor(dvs), .quotient(q3), .remainder(r3));
    apx_array_divider #(.N_BITS(4), .CELL_KIND(CELL_LOOSE_DIFF), .SWEEP(SWEEP_DIAG), .DEPTH(99))
        i_apx_array_divider_c4 (.dividend(dvd), .divisor(dvs), .quotient(q4), .remainder(r4));
    apx_array_divider #(.N_BITS(4), .CELL_KIND(CELL_LOOSE_DIFF), .SWEEP(SWEEP_ROWS), .DEPTH(5))
        i_apx_array_divider_c5 (.dividend(dvd), .divisor(dvs), .quotient(q5), .remainder(r5));

    logic cm = 0, cs = 0, cb = 0, ck = 0;
    logic e_res, e_bout, lb_res, lb_bout, ld_res, ld_bout;
    apx_sub_cell #(.KIND(CELL_EXACT))        i_cell_ex (.minu(cm), .subt(cs), .bin(cb), .keep(ck), .res(e_res),  .bout(e_bout));
    apx_sub_cell #(.KIND(CELL_LOOSE_BORROW)) i_cell_lb (.minu(cm), .subt(cs), .bin(cb), .keep(ck), .res(lb_res), .bout(lb_bout));
    apx_sub_cell #(.KIND(CELL_LOOSE_DIFF))   i_cell_ld (.minu(cm), .subt(cs), .bin(cb), .keep(ck), .res(ld_res), .bout(ld_bout));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h (dividend=%0h divisor=%0h)", tag, act, exp, dvd, dvs);
        end
    endtask

    // walk each placement order and number the cells as visited
    task automatic fill_ranks();
        int seq;
        seq = 0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin rank_tab[0][r*4+c] = seq; seq++; end
        seq = 0;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin rank_tab[1][r*4+c] = seq; seq++; end
        seq = 0;
        for (int st = 0; st < 7; st++)
            for (int r = 0; r < 4; r++) begin
                int c;
                c = st - r;
                if (c >= 0 && c < 4) begin rank_tab[2][r*4+c] = seq; seq++; end
            end
    endtask

    // bit-level reference of the array, returns {q, r}
    function automatic logic [7:0] model(input int kind, input int sw, input int depth,
                                         input int a, input int b);
        logic [3:0] part, q, sub, dflag, nxt;
        logic [4:0] x;
        logic bor, m, s, exb, loose;
        part = 4'(a >> 4);
        q = '0;
        for (int k = 0; k < 4; k++) begin
            x = {part, 1'(a >> (3 - k))};
            bor = 1'b0;
            for (int j = 0; j < 4; j++) begin
                m = x[j];
                s = 1'(b >> j);
                loose = rank_tab[sw][(3-k)*4+j] < depth;
                exb = (!m && s) || (!(m ^ s) && bor);
                sub[j] = m ^ s ^ bor;
                dflag[j] = loose && (kind == 2);
                bor = (loose && kind == 1) ? (!m && s) : exb;
            end
            q[3-k] = x[4] | !bor;
            for (int j = 0; j < 4; j++)
                nxt[j] = (dflag[j] || q[3-k]) ? sub[j] : x[j];
            part = nxt;
        end
        return {q, part};
    endfunction

    initial begin
        int lb_miss, ld_miss;
        logic [7:0] exp8;
        fill_ranks();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // first legal vector after reset: zero over one
        @(posedge clk); dvd = 8'h00; dvs = 4'h1;
        @(negedge clk);
        check(q0 == 4'h0 && r0 == 4'h0, "R1 zero dividend", {q0, r0}, 8'h00);

        // worked example
        @(posedge clk); dvd = 8'h2E; dvs = 4'hB;
        @(negedge clk);
        check(q0 == 4'h4, "R2 quotient", q0, 4);
        check(r0 == 4'h2, "R2 remainder", r0, 2);

        // single-cell truth tables
        lb_miss = 0; ld_miss = 0;
        for (int v = 0; v < 16; v++) begin
            @(posedge clk); {cm, cs, cb, ck} = 4'(v);
            @(negedge clk);
            if (lb_bout != e_bout) lb_miss++;
            if (ld_res != e_res) ld_miss++;
            check(lb_bout == (!cm && cs), "R4 loose borrow out", lb_bout, int'(!cm && cs));
            check(lb_res == e_res, "R4 loose borrow result", lb_res, e_res);
            check(ld_res == (cm ^ cs ^ cb), "R5 loose diff result", ld_res, int'(cm ^ cs ^ cb));
            check(ld_bout == e_bout, "R5 loose diff borrow", ld_bout, e_bout);
        end
        check(lb_miss == 4, "R4 mismatch row count", lb_miss, 4);
        check(ld_miss == 4, "R5 mismatch row count", ld_miss, 4);

        // all legal operand pairs
        for (int b = 1; b < 16; b++) begin
            for (int a = 0; a < b * 16; a++) begin
                @(posedge clk); dvd = 8'(a); dvs = 4'(b);
                @(negedge clk);
                check(int'(q0) == a / b, "R3 exact quotient", q0, a / b);
                check(int'(r0) == a % b, "R1 exact remainder", r0, a % b);
                exp8 = model(1, 0, 6, a, b);
                check({q1, r1} == exp8, "R6 row order loose borrow", {q1, r1}, exp8);
                exp8 = model(2, 1, 7, a, b);
                check({q2, r2} == exp8, "R7 column order loose diff", {q2, r2}, exp8);
                exp8 = model(1, 2, 9, a, b);
                check({q3, r3} == exp8, "R8 diagonal order loose borrow", {q3, r3}, exp8);
                exp8 = model(2, 2, 16, a, b);
                check({q4, r4} == exp8, "R9 R10 full loose diff", {q4, r4}, exp8);
                exp8 = model(2, 0, 5, a, b);
                check({q5, r5} == exp8, "R6 R9 row order loose diff", {q5, r5}, exp8);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule